// File: doc/BRIEF.md
# Composite-to-Quadrature FM Modulator

This block turns a stream of composite baseband samples into a frequency-modulated quadrature pair. Each accepted sample sets how far a phase accumulator moves. The step is a programmable centre increment plus the composite sample scaled by a deviation gain. The step goes through one multiply-accumulate stage.

The top bits of the accumulator address an internal sine table twice. One read is at the phase itself, which gives the sine (Q) output. The other read is a quarter turn ahead, which gives the cosine (I) output. The two results leave together with a valid flag, ready for a pair of external I/Q mixers at the audio sample rate (192000 samples per second in the intended system).

A parameter selects how the table is stored. It is either a full period or a quarter wave unfolded by symmetry. The values at the outputs are the same in both cases.

Top module: `fm_quad_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the phase accumulator clears to 0, `i_out` becomes +32767, `q_out` becomes 0 and `out_valid` becomes 0.
- R2: For each accepted strobe, the phase step is `centre_inc + ((comp_in * dev_gain) >>> 16)`. Both factors are signed 16-bit two's complement. The product is 32-bit signed, the shift is arithmetic, and the sum is taken modulo 2^32.
- R3: The 32-bit phase accumulator advances by exactly one step per accepted strobe, wraps modulo 2^32, and does not change between strobes.
- R4: Let `k` be phase bits [31:24] and let T[n] = round-half-away(32767 * sin(2*pi*n/256)). Then `q_out` = T[k] and `i_out` = T[(k+64) mod 256]. The phase used is the value after the current step.
- R5: `out_valid` is high for exactly one cycle per accepted strobe, three clock edges after the edge that samples the strobe.
- R6: With `comp_in` = 0 and `centre_inc` = 0 from reset, every output sample has `i_out` = +32767 and `q_out` = 0.
- R7: A strobe in the same cycle as `rst` is discarded. No valid pulse follows, and the next accepted strobe steps from phase 0.
- R8: `i_out` and `q_out` hold their values between valid pulses, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe: a new composite sample is present |
| comp_in | input | 16 | Signed composite sample |
| centre_inc | input | 32 | Unsigned centre phase increment per sample |
| dev_gain | input | 16 | Signed deviation gain applied to the composite sample |
| i_out | output | 16 | Signed in-phase (cosine) sample |
| q_out | output | 16 | Signed quadrature (sine) sample |
| out_valid | output | 1 | High for one cycle when `i_out`/`q_out` carry a new sample |

## Verification
Two functions can land in the same cycle: a synchronous reset and a sample strobe. The bench provokes this by raising `rst` and `smp_stb` at the same clock edge while the pipeline is idle. It then judges the result at the ports. No valid pulse may follow, the outputs must sit at the zero-phase pair, and the next strobe of one table step must give table index 1, not a position advanced by the dropped sample. The bench also overlaps back-to-back strobes with accumulator wrap-around.

// File: rtl/fmq_pkg.sv
package fmq_pkg;

   localparam real FMQ_TWO_PI = 6.283185307179586;

   // Signed table code for entry k of an n-entry period, amplitude amp,
   // rounded half away from zero.
   function automatic int sine_code(int k, int n, int amp);
      real x;
      x = real'(amp) * $sin(FMQ_TWO_PI * real'(k) / real'(n));
      return int'(x);
   endfunction

endpackage

// File: rtl/fmq_step_mac.sv
module fmq_step_mac #(
   parameter int SMP_W     = 16,
   parameter int GAIN_W    = 16,
   parameter int PHASE_W   = 32,
   parameter int DEV_SHIFT = 16
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      stb_i,
   input  logic signed [SMP_W-1:0]   comp_i,
   input  logic signed [GAIN_W-1:0]  gain_i,
   input  logic        [PHASE_W-1:0] centre_i,
   output logic        [PHASE_W-1:0] step_o,
   output logic                      vld_o
);

   localparam int PROD_W = SMP_W + GAIN_W;

   if (DEV_SHIFT >= PROD_W) begin : g_bad_shift
      $error("fmq_step_mac: DEV_SHIFT must be below the product width");
   end
   if (PHASE_W < 8) begin : g_bad_phase
      $error("fmq_step_mac: PHASE_W too small");
   end

   logic signed [PROD_W-1:0] comp_x;
   logic signed [PROD_W-1:0] gain_x;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] scaled;
   logic        [PHASE_W-1:0] step_nx;

   // single multiply-accumulate: product, arithmetic scale, add centre
   assign comp_x  = PROD_W'(comp_i);
   assign gain_x  = PROD_W'(gain_i);
   assign prod    = comp_x * gain_x;
   assign scaled  = prod >>> DEV_SHIFT;
   assign step_nx = centre_i + PHASE_W'(scaled);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         step_o <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= stb_i;
         if (stb_i) begin
            step_o <= step_nx;
         end
      end
   end

endmodule

// File: rtl/fmq_phase_acc.sv
module fmq_phase_acc #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 8
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               adv_i,
   input  logic [PHASE_W-1:0] step_i,
   output logic [ADDR_W-1:0]  idx_o,
   output logic               vld_o
);

   if (ADDR_W > PHASE_W) begin : g_bad_addr
      $error("fmq_phase_acc: ADDR_W exceeds PHASE_W");
   end

   logic [PHASE_W-1:0] phase_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= '0;
         vld_o   <= 1'b0;
      end else begin
         vld_o <= adv_i;
         if (adv_i) begin
            phase_q <= phase_q + step_i;
         end
      end
   end

   assign idx_o = phase_q[PHASE_W-1 -: ADDR_W];

   // R3
   phase_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !adv_i |=> $stable(phase_q));

endmodule

// File: rtl/fmq_sine_tap.sv
module fmq_sine_tap #(
   parameter int ADDR_W  = 8,
   parameter int OUT_W   = 16,
   parameter bit QUARTER = 1'b1
) (
   input  logic        [ADDR_W-1:0] addr_i,
   output logic signed [OUT_W-1:0]  val_o
);

   localparam int N   = 1 << ADDR_W;
   localparam int QTR = N / 4;
   localparam int AMP = (1 << (OUT_W - 1)) - 1;

   if (ADDR_W < 3 || ADDR_W > 12) begin : g_bad_addr
      $error("fmq_sine_tap: ADDR_W must lie in 3..12");
   end

   if (QUARTER) begin : g_quarter
      logic signed [OUT_W-1:0] tbl [QTR+1];
      for (genvar k = 0; k <= QTR; k++) begin : g_ent
         assign tbl[k] = OUT_W'(fmq_pkg::sine_code(k, N, AMP));
      end

      logic [1:0]        quad;
      logic [ADDR_W-3:0] off;
      logic [ADDR_W-2:0] ridx;
      logic signed [OUT_W-1:0] mag;

      assign quad = addr_i[ADDR_W-1 -: 2];
      assign off  = addr_i[ADDR_W-3:0];
      // odd quadrants read the table backwards, upper half negates
      assign ridx = quad[0] ? ((ADDR_W-1)'(QTR) - {1'b0, off}) : {1'b0, off};
      assign mag  = tbl[ridx];
      assign val_o = quad[1] ? -mag : mag;
   end else begin : g_full
      logic signed [OUT_W-1:0] tbl [N];
      for (genvar k = 0; k < N; k++) begin : g_ent
         assign tbl[k] = OUT_W'(fmq_pkg::sine_code(k, N, AMP));
      end
      assign val_o = tbl[addr_i];
   end

endmodule

// File: rtl/fmq_quad_lut.sv
module fmq_quad_lut #(
   parameter int ADDR_W  = 8,
   parameter int OUT_W   = 16,
   parameter bit QUARTER = 1'b1
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     vld_i,
   input  logic        [ADDR_W-1:0] idx_i,
   output logic signed [OUT_W-1:0]  i_o,
   output logic signed [OUT_W-1:0]  q_o,
   output logic                     vld_o
);

   localparam int N   = 1 << ADDR_W;
   localparam int AMP = (1 << (OUT_W - 1)) - 1;
   localparam longint MAG_LO = longint'(AMP - 1) * longint'(AMP - 1);
   localparam longint MAG_HI = longint'(AMP + 1) * longint'(AMP + 1);

   // tap 0: sine at the phase; tap 1: a quarter turn ahead (cosine)
   logic [ADDR_W-1:0]       tap_addr [2];
   logic signed [OUT_W-1:0] tap_val  [2];

   for (genvar t = 0; t < 2; t++) begin : g_tap
      assign tap_addr[t] = idx_i + ADDR_W'(t * (N / 4));
      fmq_sine_tap #(
         .ADDR_W (ADDR_W),
         .OUT_W  (OUT_W),
         .QUARTER(QUARTER)
      ) i_tap (
         .addr_i(tap_addr[t]),
         .val_o (tap_val[t])
      );
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         i_o   <= OUT_W'(AMP);
         q_o   <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            q_o <= tap_val[0];
            i_o <= tap_val[1];
         end
      end
   end

   // R8
   out_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !vld_i |=> ($stable(i_o) && $stable(q_o)));

   // R4
   quad_mag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      vld_o |-> ((longint'(i_o) * longint'(i_o) + longint'(q_o) * longint'(q_o)) >= MAG_LO &&
                 (longint'(i_o) * longint'(i_o) + longint'(q_o) * longint'(q_o)) <= MAG_HI));

endmodule

// File: rtl/fm_quad_mod.sv
module fm_quad_mod #(
   parameter int SMP_W     = 16,
   parameter int GAIN_W    = 16,
   parameter int PHASE_W   = 32,
   parameter int DEV_SHIFT = 16,
   parameter int ADDR_W    = 8,
   parameter int OUT_W     = 16,
   parameter bit QUARTER   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      smp_stb,
   input  logic signed [SMP_W-1:0]   comp_in,
   input  logic        [PHASE_W-1:0] centre_inc,
   input  logic signed [GAIN_W-1:0]  dev_gain,
   output logic signed [OUT_W-1:0]   i_out,
   output logic signed [OUT_W-1:0]   q_out,
   output logic                      out_valid
);

   localparam int AMP = (1 << (OUT_W - 1)) - 1;

   logic [PHASE_W-1:0] step;
   logic               step_vld;
   logic [ADDR_W-1:0]  idx;
   logic               idx_vld;

   fmq_step_mac #(
      .SMP_W    (SMP_W),
      .GAIN_W   (GAIN_W),
      .PHASE_W  (PHASE_W),
      .DEV_SHIFT(DEV_SHIFT)
   ) i_mac (
      .clk_i   (clk),
      .rst_i   (rst),
      .stb_i   (smp_stb),
      .comp_i  (comp_in),
      .gain_i  (dev_gain),
      .centre_i(centre_inc),
      .step_o  (step),
      .vld_o   (step_vld)
   );

   fmq_phase_acc #(
      .PHASE_W(PHASE_W),
      .ADDR_W (ADDR_W)
   ) i_acc (
      .clk_i (clk),
      .rst_i (rst),
      .adv_i (step_vld),
      .step_i(step),
      .idx_o (idx),
      .vld_o (idx_vld)
   );

   fmq_quad_lut #(
      .ADDR_W (ADDR_W),
      .OUT_W  (OUT_W),
      .QUARTER(QUARTER)
   ) i_lut (
      .clk_i(clk),
      .rst_i(rst),
      .vld_i(idx_vld),
      .idx_i(idx),
      .i_o  (i_out),
      .q_o  (q_out),
      .vld_o(out_valid)
   );

   // R5
   valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
      smp_stb |-> ##3 out_valid);

   // R1
   rst_state_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (i_out == OUT_W'(AMP) && q_out == '0 && !out_valid));

endmodule

// File: tb/test_fm_quad_mod.sv
module test_fm_quad_mod;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               smp_stb = 1'b0;
   logic signed [15:0] comp_in = '0;
   logic        [31:0] centre_inc = '0;
   logic signed [15:0] dev_gain = '0;
   logic signed [15:0] i_out;
   logic signed [15:0] q_out;
   logic               out_valid;

   fm_quad_mod i_fm_quad_mod (
      .clk       (clk),
      .rst       (rst),
      .smp_stb   (smp_stb),
      .comp_in   (comp_in),
      .centre_inc(centre_inc),
      .dev_gain  (dev_gain),
      .i_out     (i_out),
      .q_out     (q_out),
      .out_valid (out_valid)
   );

   always #5 clk = ~clk;

   typedef struct {
      int     ie;
      int     qe;
      longint due;
      string  tag;
   } exp_t;

   exp_t        sb[$];
   int          errors = 0;
   int          checks = 0;
   longint      cyc = 0;
   logic [31:0] ph_m = '0;
   int          last_i = 32767;
   int          last_q = 0;
   bit          done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int tab(int k);
      real x;
      x = 32767.0 * $sin(6.283185307179586 * real'(k) / 256.0);
      return int'(x);
   endfunction

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // driver: caller is at a falling edge; one-cycle strobe, expectation queued
   task automatic send(int comp, logic [31:0] centre, int gain, string tag);
      int   prod;
      int   k;
      exp_t e;
      smp_stb    = 1'b1;
      comp_in    = 16'(comp);
      centre_inc = centre;
      dev_gain   = 16'(gain);
      prod = comp * gain;                   // R2 signed product
      ph_m = ph_m + centre + 32'(prod >>> 16);
      k    = int'(ph_m[31:24]);
      e.qe  = tab(k);
      e.ie  = tab((k + 64) % 256);
      e.due = cyc + 3;
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      smp_stb = 1'b0;
   endtask

   task automatic idle(int n);
      for (int j = 0; j < n; j++) @(negedge clk);
   endtask

   // monitor: pops the scoreboard on each valid output
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R5", "valid without strobe", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.due == cyc, "R5", {e.tag, " latency"}, cyc, e.due);
            chk(int'(i_out) == e.ie, e.tag, "i_out", i_out, e.ie);
            chk(int'(q_out) == e.qe, e.tag, "q_out", q_out, e.qe);
            last_i = i_out;
            last_q = q_out;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(i_out == 16'sd32767, "R1", "i_out after reset", i_out, 32767);
      chk(q_out == 16'sd0, "R1", "q_out after reset", q_out, 0);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

      // R6 zero input, zero centre
      for (int j = 0; j < 3; j++) send(0, 32'h0, 20000, "R6");
      idle(4);
      chk(i_out == 16'sd32767 && q_out == 16'sd0, "R6", "pair held at zero phase",
          i_out, 32767);

      // R3/R4 centre-only stepping, one table index per sample
      for (int j = 0; j < 5; j++) send(0, 32'h0100_0000, 0, "R4");
      idle(4);

      // R2 positive and negative deviation, back-to-back strobes
      send(16384, 32'h0340_0000, 32767, "R2");
      send(-32768, 32'h0340_0000, 32767, "R2");
      send(20000, 32'h0200_0000, -16384, "R2");
      send(32767, 32'h0, -32768, "R2");
      send(-1, 32'h0, 1, "R2");
      idle(5);

      // R3 wrap modulo 2^32
      for (int j = 0; j < 4; j++) send(0, 32'hC000_0000, 0, "R3");
      send(12000, 32'hFFF0_0000, 30000, "R3");
      idle(5);

      // R8 outputs hold while inputs move without a strobe
      for (int j = 0; j < 6; j++) begin
         comp_in    = 16'(j * 5000);
         centre_inc = 32'h1234_5678 * 32'(j);
         dev_gain   = 16'(-j * 999);
         @(negedge clk);
         chk(int'(i_out) == last_i && int'(q_out) == last_q, "R8", "hold i_out",
             i_out, last_i);
      end

      // R7 reset and strobe in the same cycle
      rst        = 1'b1;
      smp_stb    = 1'b1;
      comp_in    = 16'sd9000;
      centre_inc = 32'h2000_0000;
      dev_gain   = 16'sd1000;
      @(negedge clk);
      rst     = 1'b0;
      smp_stb = 1'b0;
      ph_m    = '0;
      for (int j = 0; j < 5; j++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R7", "no valid after dropped strobe", out_valid, 0);
      end
      chk(i_out == 16'sd32767 && q_out == 16'sd0, "R7", "zero-phase pair", i_out, 32767);
      send(0, 32'h0100_0000, 0, "R7");
      idle(5);

      chk(sb.size() == 0, "R5", "missing outputs", sb.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule